// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block keeps the request state of a group of interrupt input pins and decides when each pin must send an interrupt message. Each pin has a routing entry, supplied from outside as flat vectors. The entry holds a vector, a destination, a logical/physical destination flag, a delivery mode, an edge/level trigger flag and a mask bit. Pin activity reaches the block as one line event per cycle, carrying a pin index and a new line level. When an entry is rewritten, a per-pin change pulse reports it. End-of-interrupt (EOI) notifications carry a vector and a trigger flag.

Each pin keeps a pending bit, a remote-acknowledge bit (level pins) and a sent flag (edge pins). Service requests are queued per pin. They are offered to a receiver over a valid/ready handshake, lowest pin index first. When the handshake completes, the receiver returns the number of destinations that accepted the message.

Level pins that stay asserted through many EOIs form an interrupt storm. The block detects this with a per-pin counter of consecutive EOI redeliveries. When the counter reaches its limit, redelivery is deferred by a fixed number of clock cycles. When that time runs out, every level pin that is pending and not awaiting acknowledge is serviced.

Top module: `irq_pin_engine`

## Requirements
- R1: After reset no delivery is offered and all pending, remote-acknowledge and sent bits are 0.
- R2: A line event with level 0 clears the pin's pending bit on the next cycle and queues no delivery.
- R3: On an edge pin (trigger flag 0), a level-1 event with the pending bit clear sets the pending bit, clears the sent flag and queues a delivery. A level-1 event with the pending bit already set is coalesced and queues nothing.
- R4: On a level pin (trigger flag 1), a level-1 event queues a delivery only when the remote-acknowledge bit is clear.
- R5: A pin whose mask bit is 1 is never offered. A queued request of a masked pin is discarded, so unmasking later does not deliver it.
- R6: A completed handshake on a level pin with a nonzero accepted count sets that pin's remote-acknowledge bit. A completed handshake on an edge pin sets its sent flag.
- R7: The offered vector, destination, destination flag, delivery mode and trigger flag are those of the offered pin's entry, and the lowest-indexed queued pin is offered first.
- R8: An EOI with trigger flag 1 clears remote-acknowledge on every level pin whose vector matches. Such a pin is redelivered on the next cycle if it is unmasked and pending. An EOI with trigger flag 0 changes nothing.
- R9: Each EOI redelivery counts per pin, and the counter clears when the EOI finds the pin masked or not pending. The STORM_LIMIT-th consecutive redelivery is instead deferred, and the counter clears. The deferred service appears DEFER_CYCLES cycles after the EOI and covers every level pin that is pending with remote-acknowledge clear.
- R10: An entry-change pulse clears the pin's remote-acknowledge bit, and a pending level pin is then queued for delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_valid | input | 1 | A line event is present this cycle |
| line_idx | input | IDX_W | Pin of the line event |
| line_lvl | input | 1 | New line level of that pin |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector |
| cfg_dest | input | NPINS*DST_W | Per-pin destination |
| cfg_dest_log | input | NPINS | Per-pin logical destination flag |
| cfg_dmode | input | NPINS*DMODE_W | Per-pin delivery mode |
| cfg_level | input | NPINS | Per-pin trigger flag, 1 = level |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| ent_chg | input | NPINS | Per-pin entry-rewritten pulse |
| eoi_valid | input | 1 | EOI notification present |
| eoi_vector | input | VEC_W | Vector of the EOI |
| eoi_level | input | 1 | Trigger flag of the EOI |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_ready | input | 1 | Receiver takes the offered delivery |
| dlv_pin | output | IDX_W | Pin being offered |
| dlv_vector | output | VEC_W | Offered vector |
| dlv_dest | output | DST_W | Offered destination |
| dlv_dest_log | output | 1 | Offered destination flag |
| dlv_dmode | output | DMODE_W | Offered delivery mode |
| dlv_level | output | 1 | Offered trigger flag |
| dlv_accepts | input | ACC_W | Destinations that accepted, valid with the handshake |
| pend_o | output | NPINS | Pending bits |
| rirr_o | output | NPINS | Remote-acknowledge bits |
| sent_o | output | NPINS | Sent flags of edge pins |

## Verification
The cycle-level assertions cover four rules: the state right after reset, the clearing of the pending bit one cycle after a low line event, the rule that no masked pin is ever offered, and the update of remote-acknowledge or the sent flag after an accepted handshake. Several behaviours depend on the history of events, so only the bench scenarios show them. These are coalescing of a repeated edge, suppression of a level assertion while acknowledge is outstanding, redelivery on a matching EOI, and the storm deferral with its exact delay and counter restart. The scenarios also show the discard of a masked request, the service triggered by an entry change, and lowest-index-first ordering.

// File: rtl/irq_eng_pkg.sv
package irq_eng_pkg;

    localparam int unsigned VEC_W   = 8;
    localparam int unsigned DST_W   = 8;
    localparam int unsigned DMODE_W = 3;

    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic [DST_W-1:0]   dest;
        logic               dest_log;
        logic [DMODE_W-1:0] dmode;
        logic               level;
        logic               mask;
    } pin_entry_t;

    // level EOI hits a level entry carrying the same vector
    function automatic logic eoi_matches(input pin_entry_t e,
                                         input logic [VEC_W-1:0] vec,
                                         input logic eoi_lvl);
        return eoi_lvl && e.level && (e.vector == vec);
    endfunction

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice #(
    parameter int unsigned STORM_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic line_hit,
    input  logic line_lvl,
    input  logic ent_level,
    input  logic ent_mask,
    input  logic ent_chg,
    input  logic eoi_hit,
    input  logic grant,
    input  logic acc_nz,
    input  logic defer_fire,
    output logic svc_o,
    output logic irr_o,
    output logic rirr_o,
    output logic sent_o,
    output logic defer_req_o
);
    localparam int unsigned CNT_W = $clog2(STORM_LIMIT + 1);

    logic             svc_q, irr_q, rirr_q, sent_q;
    logic             svc_d, irr_d, rirr_d, sent_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fresh_edge, lvl_assert, redeliver, chg_req, tmr_req, new_req;

    always_comb begin
        fresh_edge  = line_hit && line_lvl && !ent_level && !irr_q;
        lvl_assert  = line_hit && line_lvl && ent_level && !rirr_q;
        redeliver   = 1'b0;
        defer_req_o = 1'b0;
        cnt_d       = cnt_q;
        if (eoi_hit) begin
            if (!ent_mask && irr_q) begin
                if (cnt_q == CNT_W'(STORM_LIMIT - 1)) begin
                    cnt_d       = '0;
                    defer_req_o = 1'b1;
                end else begin
                    cnt_d     = cnt_q + 1'b1;
                    redeliver = 1'b1;
                end
            end else begin
                cnt_d = '0;
            end
        end
        chg_req = ent_chg && ent_level && irr_q;
        tmr_req = defer_fire && ent_level && irr_q && !rirr_q;
        new_req = fresh_edge || lvl_assert || redeliver || chg_req || tmr_req;

        svc_d  = ((svc_q && !grant) || new_req) && !ent_mask;
        irr_d  = line_hit ? line_lvl : irr_q;
        rirr_d = (eoi_hit || ent_chg) ? 1'b0 : rirr_q;
        if (grant && ent_level && acc_nz) rirr_d = 1'b1;
        sent_d = fresh_edge ? 1'b0 : sent_q;
        if (grant && !ent_level) sent_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q  <= 1'b0;
            irr_q  <= 1'b0;
            rirr_q <= 1'b0;
            sent_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            svc_q  <= svc_d;
            irr_q  <= irr_d;
            rirr_q <= rirr_d;
            sent_q <= sent_d;
            cnt_q  <= cnt_d;
        end
    end

    assign svc_o  = svc_q && !ent_mask;
    assign irr_o  = irr_q;
    assign rirr_o = rirr_q;
    assign sent_o = sent_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int unsigned NPINS = 8,
    localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NPINS-1:0] onehot
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        onehot = '0;
        if (any) onehot[idx] = 1'b1;
    end
endmodule

// File: rtl/irq_defer_timer.sv
module irq_defer_timer #(
    parameter int unsigned DELAY = 2000000
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic fire
);
    localparam int unsigned TW = $clog2(DELAY + 1);

    logic          on_q;
    logic [TW-1:0] cnt_q;

    assign fire = on_q && (cnt_q == TW'(DELAY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else if (on_q) begin
            if (fire) on_q <= 1'b0;
            else      cnt_q <= cnt_q + 1'b1;
        end else if (req) begin
            on_q  <= 1'b1;
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine
    import irq_eng_pkg::*;
#(
    parameter int unsigned NPINS        = 8,
    parameter int unsigned ACC_W        = 8,
    parameter int unsigned STORM_LIMIT  = 10000,
    parameter int unsigned DEFER_CYCLES = 2000000,
    localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     line_valid,
    input  logic [IDX_W-1:0]         line_idx,
    input  logic                     line_lvl,
    input  logic [NPINS*VEC_W-1:0]   cfg_vector,
    input  logic [NPINS*DST_W-1:0]   cfg_dest,
    input  logic [NPINS-1:0]         cfg_dest_log,
    input  logic [NPINS*DMODE_W-1:0] cfg_dmode,
    input  logic [NPINS-1:0]         cfg_level,
    input  logic [NPINS-1:0]         cfg_mask,
    input  logic [NPINS-1:0]         ent_chg,
    input  logic                     eoi_valid,
    input  logic [VEC_W-1:0]         eoi_vector,
    input  logic                     eoi_level,
    output logic                     dlv_valid,
    input  logic                     dlv_ready,
    output logic [IDX_W-1:0]         dlv_pin,
    output logic [VEC_W-1:0]         dlv_vector,
    output logic [DST_W-1:0]         dlv_dest,
    output logic                     dlv_dest_log,
    output logic [DMODE_W-1:0]       dlv_dmode,
    output logic                     dlv_level,
    input  logic [ACC_W-1:0]         dlv_accepts,
    output logic [NPINS-1:0]         pend_o,
    output logic [NPINS-1:0]         rirr_o,
    output logic [NPINS-1:0]         sent_o
);
    pin_entry_t       ents [NPINS];
    logic [NPINS-1:0] svc, pick_oh, defer_req;
    logic             defer_fire, acc_nz, take;

    assign acc_nz = |dlv_accepts;
    assign take   = dlv_valid && dlv_ready;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic line_hit, eoi_hit;

        assign ents[i].vector   = cfg_vector[i*VEC_W +: VEC_W];
        assign ents[i].dest     = cfg_dest[i*DST_W +: DST_W];
        assign ents[i].dest_log = cfg_dest_log[i];
        assign ents[i].dmode    = cfg_dmode[i*DMODE_W +: DMODE_W];
        assign ents[i].level    = cfg_level[i];
        assign ents[i].mask     = cfg_mask[i];

        assign line_hit = line_valid && (line_idx == IDX_W'(i));
        assign eoi_hit  = eoi_valid && eoi_matches(ents[i], eoi_vector, eoi_level);

        irq_pin_slice #(.STORM_LIMIT(STORM_LIMIT)) u_slice (
            .clk         (clk),
            .rst         (rst),
            .line_hit    (line_hit),
            .line_lvl    (line_lvl),
            .ent_level   (ents[i].level),
            .ent_mask    (ents[i].mask),
            .ent_chg     (ent_chg[i]),
            .eoi_hit     (eoi_hit),
            .grant       (take && pick_oh[i]),
            .acc_nz      (acc_nz),
            .defer_fire  (defer_fire),
            .svc_o       (svc[i]),
            .irr_o       (pend_o[i]),
            .rirr_o      (rirr_o[i]),
            .sent_o      (sent_o[i]),
            .defer_req_o (defer_req[i])
        );
    end

    irq_pick #(.NPINS(NPINS)) u_pick (
        .req    (svc),
        .any    (dlv_valid),
        .idx    (dlv_pin),
        .onehot (pick_oh)
    );

    irq_defer_timer #(.DELAY(DEFER_CYCLES)) u_defer (
        .clk  (clk),
        .rst  (rst),
        .req  (|defer_req),
        .fire (defer_fire)
    );

    assign dlv_vector   = ents[dlv_pin].vector;
    assign dlv_dest     = ents[dlv_pin].dest;
    assign dlv_dest_log = ents[dlv_pin].dest_log;
    assign dlv_dmode    = ents[dlv_pin].dmode;
    assign dlv_level    = ents[dlv_pin].level;

endmodule

// File: rtl/irq_eng_chk.sv
module irq_eng_chk #(
    parameter int unsigned NPINS = 8,
    parameter int unsigned ACC_W = 8,
    localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             line_valid,
    input logic [IDX_W-1:0] line_idx,
    input logic             line_lvl,
    input logic [NPINS-1:0] cfg_mask,
    input logic             dlv_valid,
    input logic             dlv_ready,
    input logic [IDX_W-1:0] dlv_pin,
    input logic             dlv_level,
    input logic [ACC_W-1:0] dlv_accepts,
    input logic [NPINS-1:0] pend_o,
    input logic [NPINS-1:0] rirr_o,
    input logic [NPINS-1:0] sent_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!dlv_valid && pend_o == '0 && rirr_o == '0 && sent_o == '0));

    // R2
    low_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (line_valid && !line_lvl) |=> !pend_o[$past(line_idx)]);

    // R5
    no_masked_offer_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> !cfg_mask[dlv_pin]);

    // R6
    level_ack_sets_rirr_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready && dlv_level && dlv_accepts != '0)
        |=> rirr_o[$past(dlv_pin)]);

    // R6
    edge_take_sets_sent_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready && !dlv_level) |=> sent_o[$past(dlv_pin)]);
endmodule

bind irq_pin_engine irq_eng_chk #(.NPINS(NPINS), .ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_valid  (line_valid),
    .line_idx    (line_idx),
    .line_lvl    (line_lvl),
    .cfg_mask    (cfg_mask),
    .dlv_valid   (dlv_valid),
    .dlv_ready   (dlv_ready),
    .dlv_pin     (dlv_pin),
    .dlv_level   (dlv_level),
    .dlv_accepts (dlv_accepts),
    .pend_o      (pend_o),
    .rirr_o      (rirr_o),
    .sent_o      (sent_o)
);

// File: tb/irq_pin_engine_tb_top.sv
`timescale 1ns/1ps
module irq_pin_engine_tb_top;
    import irq_eng_pkg::*;

    localparam int N     = 4;
    localparam int IW    = 2;
    localparam int AW    = 4;
    localparam int LIM   = 3;
    localparam int DEFER = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 line_valid = 1'b0, line_lvl = 1'b0;
    logic [IW-1:0]        line_idx = '0;
    logic [N*VEC_W-1:0]   cfg_vector;
    logic [N*DST_W-1:0]   cfg_dest;
    logic [N-1:0]         cfg_dest_log, cfg_level, cfg_mask, ent_chg = '0;
    logic [N*DMODE_W-1:0] cfg_dmode;
    logic                 eoi_valid = 1'b0, eoi_level = 1'b0;
    logic [VEC_W-1:0]     eoi_vector = '0;
    logic                 dlv_valid, dlv_ready = 1'b0, dlv_dest_log, dlv_level;
    logic [IW-1:0]        dlv_pin;
    logic [VEC_W-1:0]     dlv_vector;
    logic [DST_W-1:0]     dlv_dest;
    logic [DMODE_W-1:0]   dlv_dmode;
    logic [AW-1:0]        dlv_accepts = '0;
    logic [N-1:0]         pend_o, rirr_o, sent_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    irq_pin_engine #(.NPINS(N), .ACC_W(AW), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEFER)) dut_i (.*);

    function automatic logic [7:0] vec_of(int i); return 8'h20 + 8'(i * 17); endfunction
    function automatic logic [7:0] dst_of(int i); return 8'(i * 3 + 1); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line(int i, logic l);
        line_valid = 1'b1; line_idx = IW'(i); line_lvl = l;
        @(negedge clk);
        line_valid = 1'b0;
    endtask

    task automatic eoi(logic [7:0] v, logic l);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = l;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic take(int acc);
        dlv_ready = 1'b1; dlv_accepts = AW'(acc);
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic expect_offer(string req, int i);
        chk(req, 32'(dlv_valid), 1);
        chk(req, 32'(dlv_pin), i);
        chk({req, " (R7 vector)"}, 32'(dlv_vector), 32'(vec_of(i)));
        chk({req, " (R7 dest)"}, 32'(dlv_dest), 32'(dst_of(i)));
        chk({req, " (R7 flag)"}, 32'(dlv_dest_log), i % 2);
        chk({req, " (R7 mode)"}, 32'(dlv_dmode), i % 8);
        chk({req, " (R7 trig)"}, 32'(dlv_level), i % 2);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_vector[i*VEC_W +: VEC_W]     = vec_of(i);
            cfg_dest[i*DST_W +: DST_W]       = dst_of(i);
            cfg_dest_log[i]                  = 1'(i % 2);
            cfg_dmode[i*DMODE_W +: DMODE_W]  = DMODE_W'(i % 8);
            cfg_level[i]                     = 1'(i % 2); // pins 1,3 level
        end
        cfg_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", 32'(dlv_valid), 0);
        chk("R1 pend", 32'(pend_o), 0);
        chk("R1 rirr", 32'(rirr_o), 0);
        chk("R1 sent", 32'(sent_o), 0);

        // sweep every pin; pin 3 taken with zero accepts
        for (int i = 0; i < N; i++) begin
            line(i, 1'b1);
            expect_offer("R3/R4 first assert", i);
            take(i == 3 ? 0 : 1);
            chk("R6 after take valid", 32'(dlv_valid), 0);
            if (i % 2 == 1) chk("R6 rirr", 32'(rirr_o[i]), (i == 3) ? 0 : 1);
            else            chk("R6 sent", 32'(sent_o[i]), 1);
        end
        chk("R3 pend all", 32'(pend_o), 32'hf);

        line(0, 1'b1);
        chk("R3 coalesced", 32'(dlv_valid), 0);
        chk("R3 sent kept", 32'(sent_o[0]), 1);
        line(1, 1'b1);
        chk("R4 blocked by rirr", 32'(dlv_valid), 0);
        line(3, 1'b1);
        expect_offer("R4 rirr clear", 3);
        take(1);
        chk("R6 rirr3", 32'(rirr_o[3]), 1);

        line(2, 1'b0);
        chk("R2 pend cleared", 32'(pend_o[2]), 0);
        chk("R2 no offer", 32'(dlv_valid), 0);
        line(2, 1'b1);
        chk("R3 sent cleared", 32'(sent_o[2]), 0);
        expect_offer("R3 fresh edge", 2);
        take(1);

        eoi(vec_of(1), 1'b0);
        chk("R8 edge eoi rirr", 32'(rirr_o[1]), 1);
        chk("R8 edge eoi offer", 32'(dlv_valid), 0);
        for (int k = 1; k < LIM; k++) begin
            eoi(vec_of(1), 1'b1);
            chk("R8 rirr cleared", 32'(rirr_o[1]), 0);
            expect_offer("R8 redeliver", 1);
            take(1);
        end
        eoi(vec_of(1), 1'b1);
        repeat (DEFER - 1) @(negedge clk);
        chk("R9 held back", 32'(dlv_valid), 0);
        @(negedge clk);
        expect_offer("R9 deferred service", 1);
        take(1);
        chk("R9 pin3 not serviced", 32'(dlv_valid), 0);
        eoi(vec_of(1), 1'b1);
        expect_offer("R9 counter restarted", 1);
        take(1);

        ent_chg[3] = 1'b1;
        @(negedge clk);
        ent_chg[3] = 1'b0;
        chk("R10 rirr cleared", 32'(rirr_o[3]), 0);
        expect_offer("R10 serviced", 3);
        take(1);

        line(0, 1'b0);
        line(2, 1'b0);
        line(2, 1'b1);
        line(0, 1'b1);
        expect_offer("R7 lowest first", 0);
        take(1);
        expect_offer("R7 next", 2);
        take(1);

        cfg_mask[0] = 1'b1;
        line(0, 1'b0);
        line(0, 1'b1);
        chk("R5 masked no offer", 32'(dlv_valid), 0);
        chk("R5 pend set", 32'(pend_o[0]), 1);
        cfg_mask[0] = 1'b0;
        @(negedge clk);
        chk("R5 discarded", 32'(dlv_valid), 0);

        line(1, 1'b0);
        eoi(vec_of(1), 1'b1);
        chk("R8 not pending no offer", 32'(dlv_valid), 0);
        chk("R8 rirr cleared idle", 32'(rirr_o[1]), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule